// File: doc/BRIEF.md
# Misaligned Access Splitting Sequencer

This block sits between a load/store pipeline and the memory side of a core. It takes one load or store at a time, with a virtual address, a size of 1, 2, 4 or 8 bytes and, for stores, the store data. It first decides whether the access may go out as one operation. If it may not, the block cuts it into equal, naturally aligned pieces. Each piece is sent to an address translator and then, with the physical address it gets back, to memory.

Three runtime inputs shape the split. One picks the issue order, lowest piece first or highest piece first. One forces single-byte pieces. One sets the size of an aligned region inside which a misaligned access may still go out whole. A separate switch raises that region to at least 16 bytes. Loads are reassembled in address order whatever the issue order. Stores report the AND of the success flags of their pieces. A store-conditional whose reservation does not match the translated address fails without writing. The first fault ends the sequence and reports the virtual address of the piece that faulted.

Top module: `misalign_splitter`

## Requirements
- R1: An access whose address is a multiple of its width is issued as a single piece of the full width. Size codes on `req_size` and `mem_req_size` are 0, 1, 2 and 3 for 1, 2, 4 and 8 bytes.
- R2: A misaligned access is issued whole when it lies entirely inside one aligned region of R bytes. R is the smaller of 4096 and `cfg_atomic_lim`, which is zero or a power of two. A limit of zero disables this case.
- R3: With `cfg_floor16` high, R is raised to at least 16. An access wider than R is never issued whole while misaligned.
- R4: With `cfg_bytewise` high, a split access of W bytes becomes W one-byte pieces.
- R5: Otherwise a split access uses pieces of 2^t bytes, where t is the count of trailing zero address bits, capped at the access size. The piece count is W divided by the piece size.
- R6: Piece i has virtual address base + i × piece size. Pieces are issued from i = 0 upward when `cfg_desc` is low, and from the last piece downward when it is high.
- R7: Each piece is translated before its memory request, and the memory request carries the returned physical address and the piece size code. Translation and memory requests are never valid together.
- R8: The first translation or memory fault ends the sequence, with no further requests. It is reported with `done_fault` high and `done_vaddr` set to that piece's virtual address.
- R9: For a load, the data of piece i (right-justified on `mem_rsp_rdata`) is placed at byte lanes i × piece size upward of `done_rdata`, in any issue order. Unused upper lanes read zero.
- R10: For a store, piece i writes bytes i × piece size upward of `req_wdata`, right-justified on `mem_req_wdata`. `done_ok` is the AND of `mem_rsp_ok` over all pieces.
- R11: For a store-conditional, when `resv_valid` is low or `resv_paddr` differs from the translated address, no write is issued for that piece and `done_ok` is 0.
- R12: One request is in flight at a time. `req_ready` is high only when idle. It drops the cycle after acceptance and returns the cycle after the one-cycle `done_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_desc | input | 1 | Issue pieces highest offset first |
| cfg_bytewise | input | 1 | Split into one-byte pieces |
| cfg_atomic_lim | input | LIM_W | Whole-access region limit in bytes, 0 disables |
| cfg_floor16 | input | 1 | Raise the region to at least 16 bytes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_store | input | 1 | Request is a store |
| req_cond | input | 1 | Store is conditional on a reservation |
| req_size | input | 2 | Access size code |
| req_vaddr | input | VA_W | Virtual address |
| req_wdata | input | 64 | Store data, right-justified |
| xl_req_valid | output | 1 | Translation request valid |
| xl_req_ready | input | 1 | Translator accepts |
| xl_req_vaddr | output | VA_W | Piece virtual address |
| xl_req_write | output | 1 | Translation is for a write |
| xl_rsp_valid | input | 1 | Translation response valid |
| xl_rsp_fault | input | 1 | Translation faulted |
| xl_rsp_paddr | input | PA_W | Translated physical address |
| resv_valid | input | 1 | A reservation is held |
| resv_paddr | input | PA_W | Reserved physical address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_size | output | 2 | Piece size code |
| mem_req_paddr | output | PA_W | Piece physical address |
| mem_req_wdata | output | 64 | Piece write data, right-justified |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_fault | input | 1 | Memory access faulted |
| mem_rsp_ok | input | 1 | Write took effect |
| mem_rsp_rdata | input | 64 | Piece read data, right-justified |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Sequence ended on a fault |
| done_vaddr | output | VA_W | Virtual address of the faulting piece |
| done_rdata | output | 64 | Assembled load data |
| done_ok | output | 1 | Store or conditional store succeeded |

## Verification
On a response, the fault-abort path and the last-piece completion path are both decided in the same cycle. They collide when the piece that faults is also the last one issued. This is provoked with a page-crossing load split in two. Issued upward, the translator faults the upper page on the second and last piece. Issued downward, the same page faults on the first piece. Each run is judged by `done_vaddr`, by the translation and memory request counts seen by the bench, and by the absence of any request after the fault.

// File: rtl/misalign_splitter.sv
module misalign_splitter #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_LG = 12,
  parameter int LIM_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_desc,
  input  logic             cfg_bytewise,
  input  logic [LIM_W-1:0] cfg_atomic_lim,
  input  logic             cfg_floor16,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_store,
  input  logic             req_cond,
  input  logic [1:0]       req_size,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [63:0]      req_wdata,
  output logic             xl_req_valid,
  input  logic             xl_req_ready,
  output logic [VA_W-1:0]  xl_req_vaddr,
  output logic             xl_req_write,
  input  logic             xl_rsp_valid,
  input  logic             xl_rsp_fault,
  input  logic [PA_W-1:0]  xl_rsp_paddr,
  input  logic             resv_valid,
  input  logic [PA_W-1:0]  resv_paddr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [1:0]       mem_req_size,
  output logic [PA_W-1:0]  mem_req_paddr,
  output logic [63:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_fault,
  input  logic             mem_rsp_ok,
  input  logic [63:0]      mem_rsp_rdata,
  output logic             done_valid,
  output logic             done_fault,
  output logic [VA_W-1:0]  done_vaddr,
  output logic [63:0]      done_rdata,
  output logic             done_ok
);

  localparam logic [VA_W-1:0] PAGE_BYTES = VA_W'(1) << PAGE_LG;
  localparam logic [VA_W-1:0] FLOOR      = VA_W'(16);

  typedef enum logic [2:0] {S_IDLE, S_XREQ, S_XWAIT, S_MREQ, S_MWAIT, S_DONE} state_t;

  state_t          state_q;
  logic [VA_W-1:0] base_q;
  logic            store_q, cond_q, desc_q;
  logic [63:0]     wdata_q;
  logic [1:0]      plg_q;
  logic [2:0]      last_q, idx_q;
  logic [PA_W-1:0] paddr_q;
  logic [63:0]     acc_q;
  logic            ok_q, fault_q;
  logic [VA_W-1:0] fva_q;

  // split plan for the incoming request
  logic [VA_W-1:0] w_bytes, lim_r, min_r, reg_r, end_va;
  logic            aligned, in_region, whole;
  logic [1:0]      tz, plg_n;
  logic [2:0]      last_n;

  assign w_bytes   = VA_W'(1) << req_size;
  assign lim_r     = VA_W'(cfg_atomic_lim);
  assign min_r     = (lim_r < PAGE_BYTES) ? lim_r : PAGE_BYTES;
  assign reg_r     = (cfg_floor16 && min_r < FLOOR) ? FLOOR : min_r;
  assign end_va    = req_vaddr + w_bytes - VA_W'(1);
  assign aligned   = (req_vaddr & (w_bytes - VA_W'(1))) == '0;
  assign in_region = (reg_r != '0) && (w_bytes <= reg_r) &&
                     ((req_vaddr & ~(reg_r - VA_W'(1))) == (end_va & ~(reg_r - VA_W'(1))));
  assign whole     = aligned || in_region;

  always_comb begin
    if (req_vaddr[0])      tz = 2'd0;
    else if (req_vaddr[1]) tz = 2'd1;
    else if (req_vaddr[2]) tz = 2'd2;
    else                   tz = 2'd3;
  end

  assign plg_n  = whole ? req_size : (cfg_bytewise ? 2'd0 : ((tz < req_size) ? tz : req_size));
  assign last_n = 3'((4'd1 << (req_size - plg_n)) - 4'd1);

  // current piece
  logic [2:0]      byte_off;
  logic [3:0]      pw;
  logic [VA_W-1:0] piece_va;
  logic            is_last;
  logic [2:0]      idx_next;
  logic [63:0]     rd_shift, acc_nxt;
  logic            resv_hit;

  assign byte_off = 3'({3'b000, idx_q} << plg_q);
  assign pw       = 4'd1 << plg_q;
  assign piece_va = base_q + VA_W'(byte_off);
  assign is_last  = desc_q ? (idx_q == 3'd0) : (idx_q == last_q);
  assign idx_next = desc_q ? idx_q - 3'd1 : idx_q + 3'd1;
  assign rd_shift = mem_rsp_rdata << {byte_off, 3'b000};
  assign resv_hit = resv_valid && (resv_paddr == xl_rsp_paddr);

  always_comb begin
    acc_nxt = acc_q;
    for (int b = 0; b < 8; b++)
      if (4'(b) >= {1'b0, byte_off} && 4'(b) < {1'b0, byte_off} + pw)
        acc_nxt[8*b +: 8] = rd_shift[8*b +: 8];
  end

  assign req_ready     = state_q == S_IDLE;
  assign xl_req_valid  = state_q == S_XREQ;
  assign xl_req_vaddr  = piece_va;
  assign xl_req_write  = store_q;
  assign mem_req_valid = state_q == S_MREQ;
  assign mem_req_write = store_q;
  assign mem_req_size  = plg_q;
  assign mem_req_paddr = paddr_q;
  assign mem_req_wdata = wdata_q >> {byte_off, 3'b000};
  assign done_valid    = state_q == S_DONE;
  assign done_fault    = fault_q;
  assign done_vaddr    = fva_q;
  assign done_rdata    = acc_q;
  assign done_ok       = ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      store_q <= 1'b0;
      cond_q  <= 1'b0;
      desc_q  <= 1'b0;
      wdata_q <= '0;
      plg_q   <= '0;
      last_q  <= '0;
      idx_q   <= '0;
      paddr_q <= '0;
      acc_q   <= '0;
      ok_q    <= 1'b0;
      fault_q <= 1'b0;
      fva_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          base_q  <= req_vaddr;
          store_q <= req_store;
          cond_q  <= req_store && req_cond;
          desc_q  <= cfg_desc;
          wdata_q <= req_wdata;
          plg_q   <= plg_n;
          last_q  <= last_n;
          idx_q   <= cfg_desc ? last_n : 3'd0;
          acc_q   <= '0;
          ok_q    <= 1'b1;
          fault_q <= 1'b0;
          fva_q   <= '0;
          state_q <= S_XREQ;
        end
        S_XREQ: if (xl_req_ready) state_q <= S_XWAIT;
        S_XWAIT: if (xl_rsp_valid) begin
          if (xl_rsp_fault) begin
            fault_q <= 1'b1;
            fva_q   <= piece_va;
            state_q <= S_DONE;
          end else if (cond_q && !resv_hit) begin
            ok_q    <= 1'b0;
            idx_q   <= idx_next;
            state_q <= is_last ? S_DONE : S_XREQ;
          end else begin
            paddr_q <= xl_rsp_paddr;
            state_q <= S_MREQ;
          end
        end
        S_MREQ: if (mem_req_ready) state_q <= S_MWAIT;
        S_MWAIT: if (mem_rsp_valid) begin
          if (mem_rsp_fault) begin
            fault_q <= 1'b1;
            fva_q   <= piece_va;
            state_q <= S_DONE;
          end else begin
            if (store_q) ok_q  <= ok_q & mem_rsp_ok;
            else         acc_q <= acc_nxt;
            idx_q   <= idx_next;
            state_q <= is_last ? S_DONE : S_XREQ;
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

module misalign_splitter_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            xl_req_valid,
  input logic            xl_req_ready,
  input logic [VA_W-1:0] xl_req_vaddr,
  input logic            xl_rsp_valid,
  input logic            xl_rsp_fault,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_paddr,
  input logic            done_valid
);

  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));

  p_channels_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_req_valid && mem_req_valid));

  p_mem_follows_xlate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(xl_rsp_valid && !xl_rsp_fault));

  p_xl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req_valid && !xl_req_ready) |=> (xl_req_valid && $stable(xl_req_vaddr)));

  p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_paddr)));

endmodule

bind misalign_splitter misalign_splitter_chk #(.VA_W(VA_W), .PA_W(PA_W)) i_chk (.*);

// File: tb/test_misalign_splitter.sv
module test_misalign_splitter;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] XL_OFS = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_desc = 0, cfg_bytewise = 0, cfg_floor16 = 0;
  logic [15:0] cfg_atomic_lim = '0;
  logic req_valid = 0, req_store = 0, req_cond = 0;
  logic [1:0] req_size = '0;
  logic [31:0] req_vaddr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready;
  logic xl_req_valid, xl_req_write;
  logic xl_req_ready = 1'b1;
  logic [31:0] xl_req_vaddr;
  logic xl_rsp_valid = 0, xl_rsp_fault = 0;
  logic [31:0] xl_rsp_paddr = '0;
  logic resv_valid = 0;
  logic [31:0] resv_paddr = '0;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b1;
  logic [1:0] mem_req_size;
  logic [31:0] mem_req_paddr;
  logic [63:0] mem_req_wdata;
  logic mem_rsp_valid = 0, mem_rsp_fault = 0, mem_rsp_ok = 0;
  logic [63:0] mem_rsp_rdata = '0;
  logic done_valid, done_fault, done_ok;
  logic [31:0] done_vaddr;
  logic [63:0] done_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  misalign_splitter i_misalign_splitter (.*);

  int checks = 0, errors = 0;
  logic [7:0]  mem [0:255];
  logic [31:0] xl_log [0:15];
  logic [31:0] pa_log [0:15];
  logic [1:0]  sz_log [0:15];
  int xl_n = 0, mem_n = 0;
  logic xf_en = 0; logic [19:0] xf_page = '0;
  logic mf_en = 0; logic [31:0] mf_pa = '0;
  logic nk_en = 0; logic [31:0] nk_pa = '0;
  logic busy_bad;
  logic g_fault, g_ok; logic [31:0] g_va; logic [63:0] g_rd;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // translator and memory responders
  initial begin
    logic xp, mp; logic [31:0] xva, mpa; logic [1:0] msz; logic mw; logic [63:0] mwd;
    xp = 0; mp = 0; xva = '0; mpa = '0; msz = '0; mw = 0; mwd = '0;
    forever begin
      @(negedge clk);
      xl_rsp_valid = 0; mem_rsp_valid = 0;
      if (xp) begin
        xl_rsp_valid = 1;
        xl_rsp_fault = xf_en && (xva[31:12] == xf_page);
        xl_rsp_paddr = xva + XL_OFS;
        xp = 0;
      end
      if (mp) begin
        mem_rsp_valid = 1;
        mem_rsp_fault = mf_en && (mpa == mf_pa);
        mem_rsp_ok = !(nk_en && (mpa == nk_pa));
        mem_rsp_rdata = '0;
        for (int k = 0; k < (1 << msz); k++) begin
          if (mw && !mem_rsp_fault) mem[8'(mpa + 32'(k))] = mwd[8*k +: 8];
          mem_rsp_rdata[8*k +: 8] = mem[8'(mpa + 32'(k))];
        end
        mp = 0;
      end
      if (xl_req_valid) begin
        xva = xl_req_vaddr; xp = 1;
        if (xl_n < 16) xl_log[xl_n] = xl_req_vaddr;
        xl_n++;
      end
      if (mem_req_valid) begin
        mpa = mem_req_paddr; msz = mem_req_size; mw = mem_req_write; mwd = mem_req_wdata; mp = 1;
        if (mem_n < 16) begin pa_log[mem_n] = mem_req_paddr; sz_log[mem_n] = mem_req_size; end
        mem_n++;
      end
    end
  end

  task automatic run_req(input logic st, input logic cd, input logic [1:0] sz,
                         input logic [31:0] va, input logic [63:0] wd);
    xl_n = 0; mem_n = 0; busy_bad = 0;
    @(negedge clk);
    req_valid = 1; req_store = st; req_cond = cd; req_size = sz; req_vaddr = va; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (!done_valid) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
    end
    g_fault = done_fault; g_ok = done_ok; g_va = done_vaddr; g_rd = done_rdata;
  endtask

  // size, offset, bytewise, desc, limit, floor16, pieces, piece log2, first issued offset
  localparam int NV = 14;
  localparam logic [50:0] VEC [0:NV-1] = '{
    {2'd3, 12'h000, 1'b0, 1'b0, 16'd0,    1'b0, 4'd1, 2'd3, 12'h000},
    {2'd2, 12'h002, 1'b0, 1'b0, 16'd0,    1'b0, 4'd2, 2'd1, 12'h002},
    {2'd2, 12'h002, 1'b0, 1'b1, 16'd0,    1'b0, 4'd2, 2'd1, 12'h004},
    {2'd3, 12'h004, 1'b0, 1'b0, 16'd0,    1'b0, 4'd2, 2'd2, 12'h004},
    {2'd3, 12'h001, 1'b0, 1'b0, 16'd0,    1'b0, 4'd8, 2'd0, 12'h001},
    {2'd2, 12'h002, 1'b1, 1'b0, 16'd0,    1'b0, 4'd4, 2'd0, 12'h002},
    {2'd3, 12'h003, 1'b1, 1'b1, 16'd0,    1'b0, 4'd8, 2'd0, 12'h00A},
    {2'd2, 12'h002, 1'b0, 1'b0, 16'd8,    1'b0, 4'd1, 2'd2, 12'h002},
    {2'd2, 12'h006, 1'b0, 1'b0, 16'd8,    1'b0, 4'd2, 2'd1, 12'h006},
    {2'd3, 12'h004, 1'b0, 1'b0, 16'd0,    1'b1, 4'd1, 2'd3, 12'h004},
    {2'd3, 12'h00C, 1'b0, 1'b0, 16'd0,    1'b1, 4'd2, 2'd2, 12'h00C},
    {2'd3, 12'h004, 1'b0, 1'b0, 16'd4,    1'b0, 4'd2, 2'd2, 12'h004},
    {2'd3, 12'hFFC, 1'b0, 1'b0, 16'd8192, 1'b0, 4'd2, 2'd2, 12'hFFC},
    {2'd3, 12'h7FC, 1'b0, 1'b0, 16'd8192, 1'b0, 4'd1, 2'd3, 12'h7FC}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    // reset state (R12)
    chk(req_ready && !done_valid && !xl_req_valid && !mem_req_valid, "R12 reset idle",
        {60'd0, req_ready, done_valid, xl_req_valid, mem_req_valid}, 64'h8);
    rst_n = 1;
    @(negedge clk);

    // split plan vectors: R1 R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      logic [1:0] sz, plg; logic [11:0] off, first; logic [3:0] n;
      logic [31:0] va, exp_va; logic [63:0] exp_rd; logic ord_ok, pa_ok;
      {sz, off, cfg_bytewise, cfg_desc, cfg_atomic_lim, cfg_floor16, n, plg, first} = VEC[v];
      va = 32'h0000_2000 + 32'(off);
      run_req(0, 0, sz, va, '0);
      chk(xl_n == int'(n) && mem_n == int'(n), $sformatf("R4 R5 piece count v%0d", v), 64'(xl_n), 64'(n));
      chk(sz_log[0] == plg, $sformatf("R1 R2 R3 piece size v%0d", v), 64'(sz_log[0]), 64'(plg));
      chk(xl_log[0] == va + 32'(first) - 32'(off), $sformatf("R6 first piece v%0d", v),
          64'(xl_log[0]), 64'(va + 32'(first) - 32'(off)));
      ord_ok = 1; pa_ok = 1;
      for (int j = 0; j < int'(n) && j < 16; j++) begin
        exp_va = va + 32'((cfg_desc ? (int'(n) - 1 - j) : j) << plg);
        if (xl_log[j] != exp_va) ord_ok = 0;
        if (pa_log[j] != xl_log[j] + XL_OFS) pa_ok = 0;
      end
      chk(ord_ok, $sformatf("R6 issue order v%0d", v), 64'(ord_ok), 64'd1);
      chk(pa_ok, $sformatf("R7 translated address v%0d", v), 64'(pa_ok), 64'd1);
      exp_rd = '0;
      for (int k = 0; k < (1 << sz); k++) exp_rd[8*k +: 8] = pat(int'(8'(va + XL_OFS + 32'(k))));
      chk(g_rd == exp_rd && !g_fault, $sformatf("R9 load assembly v%0d", v), g_rd, exp_rd);
      chk(!busy_bad, $sformatf("R12 ready low while busy v%0d", v), 64'(busy_bad), 64'd0);
    end
    cfg_bytewise = 0; cfg_desc = 0; cfg_atomic_lim = '0; cfg_floor16 = 0;

    // store split (R10)
    run_req(1, 0, 2'd2, 32'h0000_2042, 64'h0000_0000_AABB_CCDD);
    chk({mem[8'h45], mem[8'h44], mem[8'h43], mem[8'h42]} == 32'hAABBCCDD && g_ok && mem_n == 2,
        "R10 store slices", {32'd0, mem[8'h45], mem[8'h44], mem[8'h43], mem[8'h42]}, 64'hAABBCCDD);
    nk_en = 1; nk_pa = 32'h0000_3054;
    run_req(1, 0, 2'd3, 32'h0000_2051, 64'h8877_6655_4433_2211);
    nk_en = 0;
    chk(!g_ok && mem_n == 8, "R10 success is AND of pieces", {63'd0, g_ok}, 64'd0);
    chk(mem[8'h54] == 8'h44 && mem[8'h58] == 8'h88, "R10 byte pieces written",
        {48'd0, mem[8'h58], mem[8'h54]}, 64'h8844);

    // fault on the last issued piece, ascending (R8)
    xf_en = 1; xf_page = 20'h00003;
    run_req(0, 0, 2'd3, 32'h0000_2FFC, '0);
    chk(g_fault && g_va == 32'h0000_3000, "R8 translation fault address", 64'(g_va), 64'h3000);
    chk(xl_n == 2 && mem_n == 1, "R8 abort after fault", 64'(mem_n), 64'd1);
    // same access descending: first issued piece faults
    cfg_desc = 1;
    run_req(0, 0, 2'd3, 32'h0000_2FFC, '0);
    chk(g_fault && g_va == 32'h0000_3000 && xl_n == 1 && mem_n == 0, "R8 descending fault",
        64'(xl_n), 64'd1);
    cfg_desc = 0; xf_en = 0;
    // memory fault on the first piece
    mf_en = 1; mf_pa = 32'h0000_3062;
    run_req(0, 0, 2'd2, 32'h0000_2062, '0);
    mf_en = 0;
    chk(g_fault && g_va == 32'h0000_2062 && xl_n == 1, "R8 memory fault address", 64'(g_va), 64'h2062);

    // store-conditional (R11)
    resv_valid = 0;
    run_req(1, 1, 2'd2, 32'h0000_2080, 64'h1122_3344);
    chk(!g_ok && mem_n == 0 && mem[8'h80] == pat(8'h80), "R11 no reservation no write",
        {63'd0, g_ok}, 64'd0);
    resv_valid = 1; resv_paddr = 32'h0000_3084;
    run_req(1, 1, 2'd2, 32'h0000_2080, 64'h1122_3344);
    chk(!g_ok && mem_n == 0, "R11 mismatched reservation", 64'(mem_n), 64'd0);
    resv_paddr = 32'h0000_3080;
    run_req(1, 1, 2'd2, 32'h0000_2080, 64'h1122_3344);
    chk(g_ok && {mem[8'h83], mem[8'h82], mem[8'h81], mem[8'h80]} == 32'h11223344,
        "R11 matching reservation writes", {32'd0, mem[8'h83], mem[8'h82], mem[8'h81], mem[8'h80]},
        64'h11223344);
    resv_valid = 0;

    @(negedge clk);
    chk(req_ready && !done_valid, "R12 idle after done", {62'd0, req_ready, done_valid}, 64'h2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule